// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is the storage back end behind a two-wire serial front end. The front end hands it byte writes as a valid/ready stream. Each write carries a byte address and a data byte. The front end also raises a one-cycle strobe when it sees a stop condition. Writes made in normal mode are gathered into a row buffer of eight bytes. On the first byte of a transaction, the buffer is filled from the row that byte belongs to. It is then committed to the storage array as a whole row once the stop arrives. While the commit runs, `busy` is high for a programmed number of cycles. The front end uses `busy` to refuse its address during that time.

The storage array is an internal register array. The counter that runs during a commit stands in for the nonvolatile programming time. Every commit rewrites all eight bytes of the row, so a per-row wear counter increases by one for each commit, however many bytes changed. With the shadow-enable input high, a write goes straight into the readable copy. Such a write starts no commit and adds no wear. Reads use a separate address and return registered data from the array.

Stream rules: a write is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole of a commit, so the producer must hold its byte until `wr_ready` returns. A stop strobe that arrives during a commit is dropped. A byte accepted in the same cycle as a stop belongs to the transaction that stop ends.

Top module: `nvpage_ctrl`

## Requirements
- R1: After reset `busy_o` is 0, `wr_ready` is 1, every array byte reads 0x00 and every wear counter reads 0.
- R2: A byte written in normal mode (`shadow_en` = 0) is not visible on the read port until its commit has finished; reads before that return the old contents.
- R3: A stop strobe with at least one buffered byte raises `busy_o` on the next cycle. `busy_o` then stays high for exactly `wt_cycles` cycles.
- R4: After a commit, every byte written in the transaction reads back its new value, and every other byte of that row keeps its earlier value.
- R5: The row of a transaction is fixed by its first byte (address bits [7:3]). Later bytes use only address bits [2:0] as their position in that row, so a write that runs past the row end wraps to the row start.
- R6: Each commit adds exactly 1 to the wear counter of the committed row (row = address bits [7:3]), whether 1 or 8 bytes changed. The counters of other rows do not change.
- R7: A wear counter saturates at its maximum value (2^WEAR_W − 1) and does not wrap.
- R8: A write with `shadow_en` = 1 updates the array directly and is readable from the next cycle. A following stop raises no busy and adds no wear.
- R9: A stop with no buffered byte, such as after an address-only write, raises no busy and adds no wear.
- R10: While `busy_o` is high, `wr_ready` is 0. A write or a stop offered during that time changes neither the array nor the length of the commit.
- R11: `rd_data` is registered: it shows the byte at `rd_addr` one clock after the address is applied and holds its value until the next edge.
- R12: A `wt_cycles` value of 0 is treated as 1, giving a busy time of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken (low during a commit) |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | DATA_W (8) | Write data byte |
| shadow_en | input | 1 | 1: write straight into the readable copy, no commit |
| stop_i | input | 1 | One-cycle stop condition strobe |
| wt_cycles | input | TIME_W (16) | Commit duration in clock cycles |
| busy_o | output | 1 | Commit in progress |
| rd_addr | input | ADDR_W (8) | Read byte address |
| rd_data | output | DATA_W (8) | Registered read data |
| wear_sel | input | ADDR_W-3 (5) | Row whose wear counter is shown |
| wear_cnt | output | WEAR_W (16) | Wear counter of the selected row |

## Verification
The bench goes after the partial-row case. In that case, bytes left untouched must come back from the preload. A design that skips the preload writes zeros or stale buffer contents over them. It also drives a transaction across the row end. A design that decodes the full address of each byte would spill into the neighbouring row instead of wrapping. It counts busy cycles for a normal write time and for a zero write time, and offers writes and stops during a commit. An off-by-one in the timer shows up as a wrong cycle count, and a leaky ready lets a byte or a restart through. Wear is checked after single-byte commits, after shadow writes and dummy stops, and past saturation with a narrow counter. Commits that are not counted, or counters that wrap, give a wrong count.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef enum logic {
    NVP_IDLE = 1'b0,
    NVP_PROG = 1'b1
  } nvp_state_e;
endpackage

// File: rtl/nvp_array.sv
module nvp_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [ADDR_W-PAGE_W-1:0]               pre_row,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]     pre_data,
  input  logic                                   bw_en,
  input  logic [ADDR_W-1:0]                      bw_addr,
  input  logic [DATA_W-1:0]                      bw_data,
  input  logic                                   rw_en,
  input  logic [ADDR_W-PAGE_W-1:0]               rw_row,
  input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]     rw_data,
  input  logic [ADDR_W-1:0]                      rd_addr,
  output logic [DATA_W-1:0]                      rd_data
);
  localparam int PB    = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < PB; g++) begin : g_pre
    assign pre_data[g] = mem[{pre_row, PAGE_W'(g)}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (rw_en) begin
        for (int i = 0; i < PB; i++) mem[{rw_row, PAGE_W'(i)}] <= rw_data[i];
      end
      if (bw_en) mem[bw_addr] <= bw_data;
      rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/nvp_pagebuf.sv
module nvp_pagebuf #(
  parameter int ROW_W  = 5,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                acc,
  input  logic [ROW_W-1:0]                    acc_row,
  input  logic [PAGE_W-1:0]                   acc_idx,
  input  logic [DATA_W-1:0]                   acc_data,
  input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]  pre_data,
  input  logic                                clr,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]  buf_q,
  output logic [(1<<PAGE_W)-1:0]              dirty_q,
  output logic [ROW_W-1:0]                    row_q
);
  localparam int PB = 1 << PAGE_W;

  logic [PB-1:0] sel;
  assign sel = PB'(1) << acc_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      dirty_q <= '0;
      row_q   <= '0;
    end else if (clr) begin
      dirty_q <= '0;
    end else if (acc) begin
      if (dirty_q == '0) begin
        row_q   <= acc_row;
        dirty_q <= sel;
        for (int i = 0; i < PB; i++)
          buf_q[i] <= sel[i] ? acc_data : pre_data[i];
      end else begin
        buf_q[acc_idx] <= acc_data;
        dirty_q        <= dirty_q | sel;
      end
    end
  end
endmodule

// File: rtl/nvp_timer.sv
module nvp_timer
  import nvp_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TIME_W-1:0] wt,
  output logic              busy,
  output logic              done
);
  nvp_state_e        state_q;
  logic [TIME_W-1:0] cnt_q;

  assign busy = (state_q == NVP_PROG);
  assign done = busy && (cnt_q == TIME_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= NVP_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        NVP_IDLE: if (start) begin
          state_q <= NVP_PROG;
          cnt_q   <= (wt == '0) ? TIME_W'(1) : wt;
        end
        NVP_PROG: begin
          if (cnt_q == TIME_W'(1)) state_q <= NVP_IDLE;
          cnt_q <= cnt_q - TIME_W'(1);
        end
        default: state_q <= NVP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvp_wear.sv
module nvp_wear #(
  parameter int ROW_W  = 5,
  parameter int WEAR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic [ROW_W-1:0]  inc_row,
  input  logic [ROW_W-1:0]  sel,
  output logic [WEAR_W-1:0] cnt
);
  localparam int ROWS = 1 << ROW_W;
  localparam logic [WEAR_W-1:0] CMAX = '1;

  logic [WEAR_W-1:0] wear_q [ROWS];

  assign cnt = wear_q[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) wear_q[i] <= '0;
    end else if (inc && wear_q[inc_row] != CMAX) begin
      wear_q[inc_row] <= wear_q[inc_row] + WEAR_W'(1);
    end
  end
endmodule

// File: rtl/nvpage_ctrl.sv
module nvpage_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3,
  parameter int WEAR_W = 16,
  parameter int TIME_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      shadow_en,
  input  logic                      stop_i,
  input  logic [TIME_W-1:0]         wt_cycles,
  output logic                      busy_o,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [ADDR_W-PAGE_W-1:0]  wear_sel,
  output logic [WEAR_W-1:0]         wear_cnt
);
  localparam int PB    = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic                          acc, acc_nv, acc_sh;
  logic                          start, done;
  logic [ROW_W-1:0]              wr_row, buf_row;
  logic [PB-1:0][DATA_W-1:0]     pre_data, buf_data;
  logic [PB-1:0]                 buf_dirty;

  assign wr_ready = !busy_o;
  assign acc      = wr_valid && wr_ready;
  assign acc_nv   = acc && !shadow_en;
  assign acc_sh   = acc && shadow_en;
  assign wr_row   = wr_addr[ADDR_W-1:PAGE_W];
  assign start    = stop_i && !busy_o && ((buf_dirty != '0) || acc_nv);

  nvp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_row  (wr_row),
    .pre_data (pre_data),
    .bw_en    (acc_sh),
    .bw_addr  (wr_addr),
    .bw_data  (wr_data),
    .rw_en    (done),
    .rw_row   (buf_row),
    .rw_data  (buf_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  nvp_pagebuf #(.ROW_W(ROW_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc_nv),
    .acc_row  (wr_row),
    .acc_idx  (wr_addr[PAGE_W-1:0]),
    .acc_data (wr_data),
    .pre_data (pre_data),
    .clr      (done),
    .buf_q    (buf_data),
    .dirty_q  (buf_dirty),
    .row_q    (buf_row)
  );

  nvp_timer #(.TIME_W(TIME_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .wt    (wt_cycles),
    .busy  (busy_o),
    .done  (done)
  );

  nvp_wear #(.ROW_W(ROW_W), .WEAR_W(WEAR_W)) u_wear (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (done),
    .inc_row (buf_row),
    .sel     (wear_sel),
    .cnt     (wear_cnt)
  );
endmodule

// File: rtl/nvp_chk.sv
module nvp_chk #(
  parameter int PB     = 8,
  parameter int WEAR_W = 16,
  parameter int ROW_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              shadow_en,
  input logic              stop_i,
  input logic              busy_o,
  input logic [ROW_W-1:0]  wear_sel,
  input logic [WEAR_W-1:0] wear_cnt,
  input logic [PB-1:0]     dirty
);
  p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  p_no_take_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !wr_ready);

  p_shadow_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && shadow_en && !stop_i && dirty == '0) |=> !busy_o);

  p_dummy_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !busy_o && dirty == '0 && !(wr_valid && wr_ready && !shadow_en))
      |=> !busy_o);

  p_wear_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o) && wear_sel == $past(wear_sel)) |-> $stable(wear_cnt));

  p_dirty_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> dirty == '0);
endmodule

bind nvpage_ctrl nvp_chk #(.PB(PB), .WEAR_W(WEAR_W), .ROW_W(ROW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .shadow_en (shadow_en),
  .stop_i    (stop_i),
  .busy_o    (busy_o),
  .wear_sel  (wear_sel),
  .wear_cnt  (wear_cnt),
  .dirty     (buf_dirty)
);

// File: tb/nvpage_ctrl_bench.sv
module nvpage_ctrl_bench;
  localparam int WEAR_W = 4;
  localparam int TIME_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [7:0]       wr_addr = '0;
  logic [7:0]       wr_data = '0;
  logic             shadow_en = 1'b0;
  logic             stop_i = 1'b0;
  logic [TIME_W-1:0] wt_cycles = 16'd3;
  logic             busy_o;
  logic [7:0]       rd_addr = '0;
  logic [7:0]       rd_data;
  logic [4:0]       wear_sel = '0;
  logic [WEAR_W-1:0] wear_cnt;

  int total = 0;
  int bad = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  nvpage_ctrl #(.WEAR_W(WEAR_W), .TIME_W(TIME_W)) u_nvpage_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .shadow_en(shadow_en),
    .stop_i(stop_i), .wt_cycles(wt_cycles), .busy_o(busy_o),
    .rd_addr(rd_addr), .rd_data(rd_data), .wear_sel(wear_sel),
    .wear_cnt(wear_cnt)
  );

  localparam logic [2:0] OP_WR = 3'd0, OP_SWR = 3'd1, OP_STOP = 3'd2,
                         OP_RD = 3'd3, OP_WEAR = 3'd4;
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] e;
  } vec_t;
  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,   8'h10, 8'h00, 8'h00},
    '{OP_WR,   8'h12, 8'hAA, 8'h00},
    '{OP_WR,   8'h13, 8'hBB, 8'h00},
    '{OP_RD,   8'h12, 8'h00, 8'h00},
    '{OP_STOP, 8'h00, 8'h00, 8'd3},
    '{OP_RD,   8'h12, 8'h00, 8'hAA},
    '{OP_RD,   8'h13, 8'h00, 8'hBB},
    '{OP_RD,   8'h10, 8'h00, 8'h00},
    '{OP_WEAR, 8'h02, 8'h00, 8'd1},
    '{OP_WR,   8'h15, 8'hCC, 8'h00},
    '{OP_STOP, 8'h00, 8'h00, 8'd3},
    '{OP_RD,   8'h12, 8'h00, 8'hAA},
    '{OP_RD,   8'h13, 8'h00, 8'hBB},
    '{OP_RD,   8'h15, 8'h00, 8'hCC},
    '{OP_WEAR, 8'h02, 8'h00, 8'd2},
    '{OP_WR,   8'h1E, 8'h11, 8'h00},
    '{OP_WR,   8'h27, 8'h22, 8'h00},
    '{OP_WR,   8'h08, 8'h33, 8'h00},
    '{OP_STOP, 8'h00, 8'h00, 8'd3},
    '{OP_RD,   8'h1E, 8'h00, 8'h11},
    '{OP_RD,   8'h1F, 8'h00, 8'h22},
    '{OP_RD,   8'h18, 8'h00, 8'h33},
    '{OP_RD,   8'h27, 8'h00, 8'h00},
    '{OP_RD,   8'h08, 8'h00, 8'h00},
    '{OP_WEAR, 8'h03, 8'h00, 8'd1},
    '{OP_WEAR, 8'h04, 8'h00, 8'd0},
    '{OP_SWR,  8'h40, 8'h5A, 8'h00},
    '{OP_RD,   8'h40, 8'h00, 8'h5A},
    '{OP_STOP, 8'h00, 8'h00, 8'd0},
    '{OP_WEAR, 8'h08, 8'h00, 8'd0},
    '{OP_STOP, 8'h00, 8'h00, 8'd0},
    '{OP_WEAR, 8'h02, 8'h00, 8'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d, input logic sh);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; shadow_en = sh;
    @(negedge clk);
    wr_valid = 1'b0; shadow_en = 1'b0;
  endtask

  task automatic do_stop(output int n);
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    n = 0;
    while (busy_o && !timed_out) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_rd(input logic [7:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic do_wear(input logic [4:0] p, output int v);
    @(negedge clk);
    wear_sel = p;
    #1 v = int'(wear_cnt);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    timed_out = 1'b1;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy_o), 0);
    check("R1 ready", int'(wr_ready), 1);
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 wear", int'(wear_cnt), 0);

    // Table walk: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR:   do_wr(VEC[i].a, VEC[i].d, 1'b0);
        OP_SWR:  do_wr(VEC[i].a, VEC[i].d, 1'b1);
        OP_STOP: begin do_stop(n); check($sformatf("R3/R9 busy len v%0d", i), n, int'(VEC[i].e)); end
        OP_RD:   begin do_rd(VEC[i].a, v); check($sformatf("R2/R4/R5/R8 rd v%0d", i), v, int'(VEC[i].e)); end
        default: begin do_wear(VEC[i].a[4:0], v); check($sformatf("R6 wear v%0d", i), v, int'(VEC[i].e)); end
      endcase
    end

    // R11: read data is registered and holds until the edge
    do_rd(8'h12, v);
    @(negedge clk);
    rd_addr = 8'h13;
    #1 check("R11 hold before edge", int'(rd_data), 8'hAA);
    @(negedge clk);
    check("R11 after edge", int'(rd_data), 8'hBB);

    // R12: zero write time acts as one cycle
    wt_cycles = '0;
    do_wr(8'h50, 8'h44, 1'b0);
    do_stop(n);
    check("R12 busy len", n, 1);
    do_rd(8'h50, v);
    check("R12 data", v, 8'h44);

    // R10: writes and stops offered during a commit
    wt_cycles = 16'd5;
    do_wr(8'h60, 8'h66, 1'b0);
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    n = 0;
    check("R10 ready low", int'(wr_ready), 0);
    wr_valid = 1'b1; wr_addr = 8'h30; wr_data = 8'h77; stop_i = 1'b1;
    n++;
    @(negedge clk);
    wr_valid = 1'b0; stop_i = 1'b0;
    while (busy_o && !timed_out) begin
      n++;
      @(negedge clk);
    end
    check("R10 busy len", n, 5);
    do_rd(8'h30, v);
    check("R10 write dropped", v, 0);
    do_wear(5'd6, v);
    check("R10 wear untouched", v, 0);
    do_rd(8'h60, v);
    check("R10 committed byte", v, 8'h66);

    // R7: wear saturates at 15 with WEAR_W = 4
    wt_cycles = 16'd1;
    for (int k = 0; k < 17; k++) begin
      do_wr(8'h01, 8'(k), 1'b0);
      do_stop(n);
    end
    do_wear(5'd0, v);
    check("R7 wear saturated", v, 15);
    do_rd(8'h01, v);
    check("R7 last data", v, 16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule